// File: doc/BRIEF.md
# Offset and Phase Sweep Measurement Controller

This block is the digital half of an on-die link measurement unit. It steps the offset code of a receiver comparator and the phase code of a sampling interpolator over a grid of points. At each point it waits a settling time, then observes the slicer output for a fixed number of samples and counts what it sees. The comparator, the interpolator and the data pattern source sit outside the block. The block only drives their codes and reads back the slicer decision and the expected bit.

The same sweep engine serves three measurements. In noise mode the input is held at a DC level. The offset is swept at phase 0, and the number of ones at each offset is stored. Software forms the cumulative curve from these counts, and the noise density from the difference between neighbouring steps. In waveform mode a periodic input is sampled in equivalent time. For each phase the block stores the first offset code at which the slicer reads one for less than half of the samples. In eye mode every grid point stores a count of mismatches between the slicer and the expected bit, which gives a two-dimensional error map. The results go into an internal memory that has a registered read port.

Top module: `sweep_meas_ctrl`

## Requirements
- R1: After reset `done` and `busy` are 0, and `off_code` and `phase_code` are 0.
- R2: A sample count of 2^`dwell_exp` is used, with `dwell_exp` clamped to the range 8..24. Each grid point takes `settle`+1 cycles of settling, then that many sample cycles, then one latch cycle. `done` rises exactly N×(settle + 2 + 2^e) cycles after the edge that accepts `start`, where N is the number of points.
- R3: The offset is the inner loop and runs from 0 to 2^OFF_W−1. The phase is the outer loop. The index {phase_code, off_code} therefore rises by one from one point to the next.
- R4: In noise mode (`mode`=0) the phase stays at 0. Only 2^OFF_W points are visited, and the number of slicer ones at offset k is stored at address k.
- R5: In waveform mode (`mode`=1), address p holds the lowest offset at which 2×ones < samples for phase p. If no offset qualifies, address p holds 2^OFF_W.
- R6: In eye mode (`mode`=2 or 3), address {phase, offset} holds the number of samples where `slicer_bit` ≠ `expect_bit`.
- R7: The error count saturates at 2^ERR_W−1 and does not wrap.
- R8: `start` is ignored while `busy` is high. `done` stays high until the next accepted `start`.
- R9: `rd_data` shows the memory word at `rd_addr` one clock after that address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a sweep when idle or finished |
| mode | input | 2 | 0 noise, 1 waveform, 2/3 eye; latched at start |
| dwell_exp | input | 5 | Log2 of samples per point (clamped 8..24) |
| settle | input | SET_W | Extra settling cycles after each code change |
| slicer_bit | input | 1 | Comparator decision |
| expect_bit | input | 1 | Expected data bit for eye mode |
| off_code | output | OFF_W | Comparator offset code |
| phase_code | output | PH_W | Interpolator phase code |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | Sweep finished |
| rd_addr | input | OFF_W+PH_W | Result read address |
| rd_data | output | 25 | Result word |

## Verification
The `done` timing is counted from the edge that accepts `start`. The bench samples `done` at the falling edge just before and just after the edge on which it is due. This includes a run whose requested sample exponent is below the minimum, so the clamp shows up in the count. The slicer model changes only at falling edges, and the codes change only at latch edges. As a result every sample window sees a known number of ones or errors, and the scoreboard predicts each stored word from the requirement alone. A monitor reads each result one clock after it sets the read address. Another monitor checks at every falling edge that the code index steps by exactly one.

// File: rtl/sweep_pkg.sv
// Shared types for the sweep measurement controller.
// Assumes: mode encodings are fixed by the requirements (0 noise, 1 wave, else eye).
package sweep_pkg;
    typedef enum logic [1:0] {
        M_NOISE = 2'd0,
        M_WAVE  = 2'd1,
        M_EYE   = 2'd2,
        M_EYE2  = 2'd3
    } meas_mode_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SETTLE,
        S_DWELL,
        S_LATCH,
        S_FIN
    } seq_state_t;
endpackage

// File: rtl/sweep_seq.sv
// Point sequencer: walks offset (inner) and phase (outer), times settle,
// dwell and latch phases of every grid point.
// Assumes: SET_W <= CNT_W; inputs other than start are sampled only at start.
module sweep_seq
    import sweep_pkg::*;
#(
    parameter int OFF_W   = 4,
    parameter int PH_W    = 3,
    parameter int SET_W   = 8,
    parameter int EXP_MIN = 8,
    parameter int EXP_MAX = 24,
    parameter int CNT_W   = EXP_MAX + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       mode_in,
    input  logic [4:0]       dwell_exp,
    input  logic [SET_W-1:0] settle,
    output meas_mode_t       mode_q,
    output logic [OFF_W-1:0] off_code,
    output logic [PH_W-1:0]  phase_code,
    output logic [CNT_W-1:0] dwell_len,
    output logic             clear,
    output logic             sample_en,
    output logic             latch,
    output logic             last_off,
    output logic             busy,
    output logic             done
);
    localparam logic [OFF_W-1:0] OFF_MAX = {OFF_W{1'b1}};
    localparam logic [PH_W-1:0]  PH_MAX  = {PH_W{1'b1}};

    seq_state_t       state;
    logic [CNT_W-1:0] cnt;
    logic [SET_W-1:0] settle_q;
    logic [4:0]       exp_q;
    logic [4:0]       exp_clamp;
    logic             last_ph;

    // Clamp the requested dwell exponent into the supported window.
    always_comb begin
        if (dwell_exp < 5'(EXP_MIN))      exp_clamp = 5'(EXP_MIN);
        else if (dwell_exp > 5'(EXP_MAX)) exp_clamp = 5'(EXP_MAX);
        else                              exp_clamp = dwell_exp;
    end

    // Decode point boundaries and phase of the point cycle.
    always_comb begin
        dwell_len = CNT_W'(1) << exp_q;
        last_off  = (off_code == OFF_MAX);
        last_ph   = (mode_q == M_NOISE) || (phase_code == PH_MAX);
        clear     = (state == S_SETTLE);
        sample_en = (state == S_DWELL);
        latch     = (state == S_LATCH);
        busy      = (state == S_SETTLE) || (state == S_DWELL) || (state == S_LATCH);
        done      = (state == S_FIN);
    end

    // Main sequencing state machine with code stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            cnt        <= '0;
            off_code   <= '0;
            phase_code <= '0;
            mode_q     <= M_NOISE;
            settle_q   <= '0;
            exp_q      <= 5'(EXP_MIN);
        end else begin
            case (state)
                S_IDLE, S_FIN: begin
                    if (start) begin
                        state      <= S_SETTLE;
                        cnt        <= '0;
                        off_code   <= '0;
                        phase_code <= '0;
                        mode_q     <= meas_mode_t'(mode_in);
                        settle_q   <= settle;
                        exp_q      <= exp_clamp;
                    end
                end
                S_SETTLE: begin
                    if (cnt == CNT_W'(settle_q)) begin
                        cnt   <= '0;
                        state <= S_DWELL;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                S_DWELL: begin
                    if (cnt == dwell_len - 1'b1) begin
                        cnt   <= '0;
                        state <= S_LATCH;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                S_LATCH: begin
                    cnt <= '0;
                    if (last_off) begin
                        off_code <= '0;
                        if (last_ph) begin
                            state <= S_FIN;
                        end else begin
                            phase_code <= phase_code + 1'b1;
                            state      <= S_SETTLE;
                        end
                    end else begin
                        off_code <= off_code + 1'b1;
                        state    <= S_SETTLE;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R3: codes hold steady across every sample window.
    p_codes_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DWELL) |-> ($stable(off_code) && $stable(phase_code)));
    // R4: noise sweeps never leave phase 0.
    p_noise_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mode_q == M_NOISE) |-> (phase_code == '0));
    // R8: done and busy are exclusive.
    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R2: the active dwell exponent stays inside the window.
    p_exp_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (exp_q >= 5'(EXP_MIN) && exp_q <= 5'(EXP_MAX)));
endmodule

// File: rtl/sweep_accum.sv
// Per-point counters: ones count, saturating error count and the
// half-threshold crossing search used by waveform capture.
// Assumes: clear is high for at least one cycle before each sample window.
module sweep_accum #(
    parameter int OFF_W = 4,
    parameter int CNT_W = 25,
    parameter int ERR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             sample_en,
    input  logic             latch,
    input  logic             slicer_bit,
    input  logic             expect_bit,
    input  logic [CNT_W-1:0] dwell_len,
    input  logic [OFF_W-1:0] off_code,
    output logic [CNT_W-1:0] ones_cnt,
    output logic [ERR_W-1:0] err_cnt,
    output logic             hit_now,
    output logic [OFF_W-1:0] hit_code
);
    localparam logic [ERR_W-1:0] ERR_MAX = {ERR_W{1'b1}};

    logic             found;
    logic [OFF_W-1:0] found_code;
    logic             below_half;
    logic             first_off;

    // Threshold test and crossing result for the point being latched.
    always_comb begin
        below_half = ({ones_cnt, 1'b0} < {1'b0, dwell_len});
        first_off  = (off_code == '0);
        hit_now    = (!first_off && found) || below_half;
        hit_code   = (!first_off && found) ? found_code : off_code;
    end

    // Count ones and saturating mismatches during the sample window.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            ones_cnt <= '0;
            err_cnt  <= '0;
        end else if (sample_en) begin
            if (slicer_bit) ones_cnt <= ones_cnt + 1'b1;
            if ((slicer_bit != expect_bit) && (err_cnt != ERR_MAX))
                err_cnt <= err_cnt + 1'b1;
        end
    end

    // Remember the first below-half offset of the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            found      <= 1'b0;
            found_code <= '0;
        end else if (latch) begin
            found <= hit_now;
            if ((first_off || !found) && below_half) found_code <= off_code;
        end
    end

    // R7: a saturated error count stays saturated.
    p_err_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en && err_cnt == ERR_MAX) |=> (err_cnt == ERR_MAX));
    // R2: no more ones than samples in a window.
    p_ones_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en |-> (ones_cnt < dwell_len));
endmodule

// File: rtl/result_ram.sv
// Result store: one write port, one registered read port.
// Assumes: unwritten entries are don't-care to the reader.
module result_ram #(
    parameter int AW = 7,
    parameter int DW = 25
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Store results and return the addressed word one cycle later.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
        rd_data <= mem[rd_addr];
    end
endmodule

// File: rtl/sweep_meas_ctrl.sv
// Top of the offset/phase sweep measurement controller: sequencer,
// accumulators and result memory, with mode-dependent write mapping.
// Assumes: slicer_bit and expect_bit are synchronous to clk.
module sweep_meas_ctrl
    import sweep_pkg::*;
#(
    parameter int OFF_W   = 4,
    parameter int PH_W    = 3,
    parameter int ERR_W   = 8,
    parameter int SET_W   = 8,
    parameter int EXP_MIN = 8,
    parameter int EXP_MAX = 24
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [1:0]            mode,
    input  logic [4:0]            dwell_exp,
    input  logic [SET_W-1:0]      settle,
    input  logic                  slicer_bit,
    input  logic                  expect_bit,
    output logic [OFF_W-1:0]      off_code,
    output logic [PH_W-1:0]       phase_code,
    output logic                  busy,
    output logic                  done,
    input  logic [OFF_W+PH_W-1:0] rd_addr,
    output logic [EXP_MAX:0]      rd_data
);
    localparam int CNT_W = EXP_MAX + 1;
    localparam int AW    = OFF_W + PH_W;
    localparam int OFF_N = 1 << OFF_W;

    meas_mode_t       mode_q;
    logic [CNT_W-1:0] dwell_len;
    logic             clear, sample_en, latch, last_off;
    logic [CNT_W-1:0] ones_cnt;
    logic [ERR_W-1:0] err_cnt;
    logic             hit_now;
    logic [OFF_W-1:0] hit_code;
    logic             wr_en;
    logic [AW-1:0]    wr_addr;
    logic [CNT_W-1:0] wr_data;

    sweep_seq #(
        .OFF_W(OFF_W), .PH_W(PH_W), .SET_W(SET_W),
        .EXP_MIN(EXP_MIN), .EXP_MAX(EXP_MAX), .CNT_W(CNT_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_in(mode),
        .dwell_exp(dwell_exp), .settle(settle), .mode_q(mode_q),
        .off_code(off_code), .phase_code(phase_code), .dwell_len(dwell_len),
        .clear(clear), .sample_en(sample_en), .latch(latch),
        .last_off(last_off), .busy(busy), .done(done)
    );

    sweep_accum #(.OFF_W(OFF_W), .CNT_W(CNT_W), .ERR_W(ERR_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .clear(clear), .sample_en(sample_en),
        .latch(latch), .slicer_bit(slicer_bit), .expect_bit(expect_bit),
        .dwell_len(dwell_len), .off_code(off_code), .ones_cnt(ones_cnt),
        .err_cnt(err_cnt), .hit_now(hit_now), .hit_code(hit_code)
    );

    // Map the latched point to its result word and address per mode.
    always_comb begin
        wr_en   = latch;
        wr_addr = AW'(off_code);
        wr_data = ones_cnt;
        case (mode_q)
            M_NOISE: ;
            M_WAVE: begin
                wr_en   = latch && last_off;
                wr_addr = AW'(phase_code);
                wr_data = hit_now ? CNT_W'(hit_code) : CNT_W'(OFF_N);
            end
            default: begin
                wr_addr = {phase_code, off_code};
                wr_data = CNT_W'(err_cnt);
            end
        endcase
    end

    result_ram #(.AW(AW), .DW(CNT_W)) u_ram (
        .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // R5: waveform results land only once per phase, at the last offset.
    p_wave_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && mode_q == M_WAVE) |-> (off_code == {OFF_W{1'b1}}));
    // R1: nothing is written outside a sweep.
    p_idle_nowrite_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> busy);
endmodule

// File: tb/tb_sweep_meas_ctrl.sv
// Scoreboard bench: a driver pushes expected result words, a monitor
// reads the result memory back and compares.
module tb_sweep_meas_ctrl;
    localparam int OFF_W = 4;
    localparam int PH_W  = 3;
    localparam int ERR_W = 8;
    localparam int OFF_N = 1 << OFF_W;
    localparam int PH_N  = 1 << PH_W;
    localparam int AW    = OFF_W + PH_W;
    localparam int DC_K  = 9;

    typedef struct {
        int    addr;
        int    val;
        string tag;
    } exp_item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [1:0]    mode = 2'd0;
    logic [4:0]    dwell_exp = 5'd8;
    logic [7:0]    settle = 8'd0;
    logic          slicer_bit;
    logic          expect_bit;
    logic [OFF_W-1:0] off_code;
    logic [PH_W-1:0]  phase_code;
    logic          busy, done;
    logic [AW-1:0] rd_addr = '0;
    logic [24:0]   rd_data;

    int checks = 0;
    int errors = 0;
    logic tg = 1'b0;
    int bench_mode = 0;
    int prev_idx = -1;
    int order_err = 0;
    exp_item_t sb_q[$];

    always #4 clk = ~clk;

    sweep_meas_ctrl #(.OFF_W(OFF_W), .PH_W(PH_W), .ERR_W(ERR_W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .dwell_exp(dwell_exp), .settle(settle), .slicer_bit(slicer_bit),
        .expect_bit(expect_bit), .off_code(off_code), .phase_code(phase_code),
        .busy(busy), .done(done), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // Toggle used for half-density slicer activity; changes away from posedge.
    always @(negedge clk) tg <= ~tg;

    function automatic int wave_thr(int ph);
        return (ph * 5 + 3) % 16;
    endfunction

    // Comparator/pattern model of the analog side.
    always_comb begin
        int o, p;
        o = int'(off_code);
        p = int'(phase_code);
        expect_bit = tg ^ off_code[0];
        case (bench_mode)
            0: slicer_bit = (o < DC_K) ? 1'b1 : (o == DC_K) ? tg : 1'b0;
            1: begin
                if (p == PH_N - 1) slicer_bit = 1'b1;
                else slicer_bit = (o < wave_thr(p)) ? 1'b1 : (o == wave_thr(p)) ? tg : 1'b0;
            end
            default: begin
                if (o >= 12)     slicer_bit = ~expect_bit;
                else if (o == p) slicer_bit = expect_bit ^ tg;
                else             slicer_bit = expect_bit;
            end
        endcase
    end

    // R3 order monitor: index {phase,offset} must step by one.
    always @(negedge clk) begin
        if (busy) begin
            int idx;
            idx = int'({phase_code, off_code});
            if (idx != prev_idx) begin
                if (idx != prev_idx + 1) order_err++;
                prev_idx = idx;
            end
        end
    end

    task automatic check(bit ok, string req, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic push(int addr, int val, string tag);
        exp_item_t it;
        it.addr = addr; it.val = val; it.tag = tag;
        sb_q.push_back(it);
    endtask

    // Monitor: read each expected address, result due one clock later (R9).
    task automatic drain();
        while (sb_q.size() > 0) begin
            exp_item_t it;
            it = sb_q.pop_front();
            @(negedge clk);
            rd_addr = AW'(it.addr);
            @(posedge clk);
            @(negedge clk);
            check(int'(rd_data) == it.val, it.tag, int'(rd_data), it.val);
        end
    endtask

    // Run one sweep and check done timing (R2, R8).
    task automatic run(int md, int ex, int st, int npts, int per, bit inject);
        int total;
        total = npts * per;
        @(negedge clk);
        bench_mode = md;
        mode = 2'(md);
        dwell_exp = 5'(ex);
        settle = 8'(st);
        prev_idx = -1;
        order_err = 0;
        start = 1'b1;
        @(posedge clk);
        for (int k = 1; k <= total; k++) begin
            @(negedge clk);
            start = (inject && k == 1000) ? 1'b1 : 1'b0;
            if (inject && k == 1000) mode = 2'd2;
        end
        check(done == 1'b0, "R2 done not early", int'(done), 0);
        @(negedge clk);
        check(done == 1'b1, "R2 done on time", int'(done), 1);
        @(negedge clk);
        check(done == 1'b1 && busy == 1'b0, "R8 done held", int'(done), 1);
        check(order_err == 0, "R3 code order", order_err, 0);
        check(prev_idx == npts - 1, "R3 point count", prev_idx, npts - 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(done == 1'b0 && busy == 1'b0, "R1 reset flags", int'({done, busy}), 0);
        check(off_code == '0 && phase_code == '0, "R1 reset codes",
              int'({phase_code, off_code}), 0);
        rst_n = 1'b1;

        // Noise mode, requested exponent 3 clamps to 8; start pulsed mid-run (R8).
        run(0, 3, 3, OFF_N, 3 + 2 + 256, 1'b1);
        for (int k = 0; k < OFF_N; k++)
            push(k, (k < DC_K) ? 256 : (k == DC_K) ? 128 : 0, "R4 noise ones");
        drain();

        // Waveform mode: crossing at thr+1, last phase never crosses (R5).
        run(1, 8, 0, OFF_N * PH_N, 0 + 2 + 256, 1'b0);
        for (int p = 0; p < PH_N; p++)
            push(p, (p == PH_N - 1) ? OFF_N : wave_thr(p) + 1, "R5 wave crossing");
        drain();

        // Eye mode: saturation at offsets >= 12 (R7), half errors on diagonal (R6).
        run(2, 8, 0, OFF_N * PH_N, 0 + 2 + 256, 1'b0);
        for (int p = 0; p < PH_N; p++)
            for (int o = 0; o < OFF_N; o++)
                push(p * OFF_N + o, (o >= 12) ? 255 : (o == p) ? 128 : 0,
                     (o >= 12) ? "R7 error saturate" : "R6 eye errors");
        drain();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule